// File: doc/BRIEF.md
# Dual-Lane Serial ADC Frame Controller

This block is the host side of a serial link to a two-channel analog-to-digital converter that returns its two results on two separate data lines. It acts as the clock master. It drives an active-low chip select, a serial clock and a command line, and it samples both data lines together.

The converter starts up in a 32-clock readout mode, so the first frame after reset is a long one. That frame carries the configuration write `0x8800` followed by a zero word, with chip select held low for all 32 clocks. This write selects 16-clock reads and dual data outputs. Every later trigger starts a 16-clock read frame. In a read frame the command line stays at zero, and each data line is shifted in MSB first. When the frame closes, both words go into the result registers and a one-cycle valid strobe is raised.

Sequencer states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | chip select released |
| `ST_LEAD` | chip select low, clock still low |
| `ST_HIGH` | clock high |
| `ST_LOW` | clock low between bits |
| `ST_TRAIL` | clock low after the last bit, chip select still low |

Transitions:

| From | To | Condition |
|------|----|-----------|
| IDLE | LEAD | trigger |
| LEAD | HIGH | half-period tick (rising edge) |
| HIGH | LOW | tick, bits remain (falling edge) |
| HIGH | TRAIL | tick on the last bit (falling edge) |
| LOW | HIGH | tick (rising edge) |
| TRAIL | IDLE | tick (chip select released, results committed) |

Top module: `adc_dual_sdo_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released:
  - `cs_n` is 1 and `sclk` is 0.
  - `busy` and `res_valid` are 0.
  - `res_a` and `res_b` are 0.
- R2: The first frame after reset is a configuration frame:
  - It has exactly 32 falling edges of `sclk`, with `cs_n` held low throughout.
  - Taking `mosi` at each falling edge, MSB first, gives 32'h8800_0000.
  - Bits 15:12 = 4'h8 form the register-write code, bit 11 = 1 selects 16-clock reads and bit 10 = 0 selects dual outputs.
  - It produces no `res_valid` pulse.
- R3: Every later frame is a read frame of exactly 16 falling edges, with `mosi` at 0 on every one of them.
- R4: In a read frame, `sdo_a` and `sdo_b` are sampled at each falling edge of `sclk`, MSB first. They form `res_a` and `res_b` respectively.
- R5: When a read frame ends, `res_valid` is high for exactly one system clock.
  - That is the same cycle in which `cs_n` returns high and the new results appear.
  - The results do not change in any other cycle.
- R6: `sclk` is low whenever `cs_n` is high, and `mosi` changes only in a cycle where `sclk` rises.
- R7: The `sclk` high and low phases each last CLK_DIV/2 system clocks.
  - `cs_n` falls CLK_DIV/2 clocks before the first rising edge.
  - `cs_n` rises CLK_DIV/2 clocks after the last falling edge.
- R8: A trigger is accepted only while `busy` is 0.
  - `busy` is 1 for the whole time `cs_n` is low.
  - A trigger pulse during a frame starts no further frame and causes no extra `res_valid` pulse.
- R9: While `cs_n` is high, activity on `sdo_a` and `sdo_b` changes neither the results nor `res_valid`.
- R10: A reset makes the block forget that the converter was configured, so the next frame is again a 32-clock configuration frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| trigger | input | 1 | starts a frame when the block is idle |
| cs_n | output | 1 | converter chip select, active low |
| sclk | output | 1 | serial clock, idles low |
| mosi | output | 1 | command data to the converter |
| sdo_a | input | 1 | converter data line for channel A |
| sdo_b | input | 1 | converter data line for channel B |
| res_a | output | WORD_W | last channel A result |
| res_b | output | WORD_W | last channel B result |
| res_valid | output | 1 | one-cycle strobe when new results are loaded |
| busy | output | 1 | a frame is in progress |

## Verification
The hardest case to reach is a trigger that lands in the middle of a frame. It must leave the bit counter, the shift registers and the next frame untouched. The bench gets there by pulsing the trigger for one cycle right after the third falling clock edge of a read frame. It then confirms that the frame still ends after 16 edges with the right data, and that the line stays idle afterwards. Activity on the data lines outside a frame is reached by driving the converter model's idle values directly while chip select is high. A second reset partway through the run shows that the long configuration frame comes back.

// File: rtl/adc_dual_sdo_pkg.sv
package adc_dual_sdo_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } seq_state_t;

    // Converter configuration fields (the converter decodes these positions)
    localparam logic [3:0] CMD_CFG_WRITE = 4'h8;  // bits 15:12
    localparam logic       CFG_RD16      = 1'b1;  // bit 11: 16-clock reads
    localparam logic       CFG_SINGLE    = 1'b0;  // bit 10: 0 = dual outputs

endpackage

// File: rtl/adc_half_timer.sv
// Free-running half-period counter for the serial clock; held at zero when idle.
module adc_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !hold && (cnt_q == LAST);
endmodule

// File: rtl/adc_cmd_shifter.sv
// Command shift register: launches one bit per rising serial-clock edge.
module adc_cmd_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    output logic               mosi
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (shift) begin
            mosi <= sr_q[FRAME_W-1];
            sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/adc_lane_capture.sv
// Parallel capture of the converter data lines, one shift register per lane.
module adc_lane_capture #(
    parameter int WORD_W = 16,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample,
    input  logic [LANES-1:0]              sdo,
    input  logic                          commit,
    output logic [LANES-1:0][WORD_W-1:0]  result
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] sr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sr_q      <= '0;
                result[g] <= '0;
            end else begin
                if (sample) begin
                    sr_q <= {sr_q[WORD_W-2:0], sdo[g]};
                end
                if (commit) begin
                    result[g] <= sr_q;
                end
            end
        end
    end
endmodule

// File: rtl/adc_frame_seq.sv
// Frame sequencer: chip select, serial clock phases, bit count, config tracking.
module adc_frame_seq
    import adc_dual_sdo_pkg::*;
#(
    parameter int CFG_BITS = 32,
    parameter int RD_BITS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic tick,
    output logic timer_hold,
    output logic rise_en,
    output logic fall_en,
    output logic load_tx,
    output logic load_cfg,
    output logic commit,
    output logic cs_n,
    output logic sclk,
    output logic busy,
    output logic res_valid
);
    localparam int BW = $clog2(CFG_BITS + 1);

    seq_state_t     state_q, state_nx;
    logic [BW-1:0]  bits_q;
    logic           cfg_done_q;
    logic           is_cfg_q;
    logic           accept;
    logic           end_frame;

    assign accept    = (state_q == ST_IDLE) && trigger;
    assign end_frame = (state_q == ST_TRAIL) && tick;

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (trigger) state_nx = ST_LEAD;
            ST_LEAD:  if (tick)    state_nx = ST_HIGH;
            ST_HIGH:  if (tick)    state_nx = (bits_q == BW'(1)) ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)    state_nx = ST_HIGH;
            ST_TRAIL: if (tick)    state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Frame bookkeeping: remaining bits, frame kind, configured flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q     <= '0;
            is_cfg_q   <= 1'b0;
            cfg_done_q <= 1'b0;
        end else begin
            if (accept) begin
                bits_q   <= cfg_done_q ? BW'(RD_BITS) : BW'(CFG_BITS);
                is_cfg_q <= !cfg_done_q;
            end else if (fall_en) begin
                bits_q <= bits_q - 1'b1;
            end
            if (end_frame && is_cfg_q) begin
                cfg_done_q <= 1'b1;
            end
        end
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            busy      <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            cs_n      <= (state_nx == ST_IDLE);
            sclk      <= (state_nx == ST_HIGH);
            busy      <= (state_nx != ST_IDLE);
            res_valid <= end_frame && !is_cfg_q;
        end
    end

    // Strobes to the datapath
    assign timer_hold = (state_q == ST_IDLE);
    assign rise_en    = tick && ((state_q == ST_LEAD) || (state_q == ST_LOW));
    assign fall_en    = tick && (state_q == ST_HIGH);
    assign load_tx    = accept;
    assign load_cfg   = !cfg_done_q;
    assign commit     = end_frame && !is_cfg_q;
endmodule

// File: rtl/adc_dual_sdo_ctrl.sv
module adc_dual_sdo_ctrl
    import adc_dual_sdo_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int WORD_W    = 16,
    parameter int CFG_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              sdo_a,
    input  logic              sdo_b,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_b,
    output logic              res_valid,
    output logic              busy
);
    localparam int HALF     = CLK_DIV / 2;
    localparam int LANES    = 2;
    localparam int CFG_BITS = CFG_WORDS * WORD_W;
    localparam logic [WORD_W-1:0] CFG_WORD =
        {CMD_CFG_WRITE, CFG_RD16, CFG_SINGLE, {(WORD_W-6){1'b0}}};
    localparam logic [CFG_BITS-1:0] CFG_FRAME =
        {CFG_WORD, {(CFG_BITS-WORD_W){1'b0}}};

    logic tick, timer_hold, rise_en, fall_en, load_tx, load_cfg, commit;
    logic [LANES-1:0][WORD_W-1:0] result;

    adc_half_timer #(.HALF(HALF)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (timer_hold),
        .tick  (tick)
    );

    adc_frame_seq #(.CFG_BITS(CFG_BITS), .RD_BITS(WORD_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trigger    (trigger),
        .tick       (tick),
        .timer_hold (timer_hold),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .load_tx    (load_tx),
        .load_cfg   (load_cfg),
        .commit     (commit),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .busy       (busy),
        .res_valid  (res_valid)
    );

    adc_cmd_shifter #(.FRAME_W(CFG_BITS)) i_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_tx),
        .load_word (load_cfg ? CFG_FRAME : '0),
        .shift     (rise_en),
        .mosi      (mosi)
    );

    adc_lane_capture #(.WORD_W(WORD_W), .LANES(LANES)) i_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (fall_en),
        .sdo    ({sdo_b, sdo_a}),
        .commit (commit),
        .result (result)
    );

    assign res_a = result[0];
    assign res_b = result[1];
endmodule

// File: rtl/adc_dual_sdo_chk.sv
module adc_dual_sdo_chk #(
    parameter int CFG_BITS = 32,
    parameter int RD_BITS  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               sclk,
    input logic               mosi,
    input logic               busy,
    input logic               res_valid,
    input logic [RD_BITS-1:0] res_a,
    input logic [RD_BITS-1:0] res_b
);
    localparam int CW = $clog2(CFG_BITS + 1) + 1;

    logic          sclk_d, cs_d, seen_cfg;
    logic [CW-1:0] falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            cs_d     <= 1'b1;
            seen_cfg <= 1'b0;
            falls    <= '0;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
            if (cs_n && !cs_d) begin
                falls    <= '0;
                seen_cfg <= 1'b1;
            end else if (sclk_d && !sclk) begin
                falls <= falls + 1'b1;
            end
        end
    end

    // R2 R3 R10
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_d) |-> (falls == (seen_cfg ? CW'(RD_BITS) : CW'(CFG_BITS))));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R5
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_a) && $stable(res_b)));

    // R2 R9
    valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cs_n && !cs_d && seen_cfg));

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk && !sclk_d) |-> $stable(mosi));

    // R8
    busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
endmodule

bind adc_dual_sdo_ctrl adc_dual_sdo_chk #(
    .CFG_BITS (CFG_WORDS * WORD_W),
    .RD_BITS  (WORD_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .busy      (busy),
    .res_valid (res_valid),
    .res_a     (res_a),
    .res_b     (res_b)
);

// File: tb/test_adc_dual_sdo_ctrl.sv
module test_adc_dual_sdo_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int HALF       = CLK_DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trigger = 1'b0;
    logic cs_n, sclk, mosi, res_valid, busy;
    logic [15:0] res_a, res_b;
    logic sa = 1'b1, sb = 1'b1, idle_a = 1'b1, idle_b = 1'b1;
    logic [15:0] pat_a = '0, pat_b = '0;
    int s_rise = 0;
    int checks = 0, errors = 0;

    wire sdo_a = cs_n ? idle_a : sa;
    wire sdo_b = cs_n ? idle_b : sb;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_dual_sdo_ctrl #(.CLK_DIV(CLK_DIV)) i_adc_dual_sdo_ctrl (
        .clk(clk), .rst_n(rst_n), .trigger(trigger),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .sdo_a(sdo_a), .sdo_b(sdo_b),
        .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .busy(busy)
    );

    // Converter model: first bit at chip-select fall, next bits on rising clocks
    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            s_rise = 0;
            sa = pat_a[15];
            sb = pat_b[15];
        end else begin
            if (s_rise > 0 && s_rise < 16) begin
                sa = pat_a[15 - s_rise];
                sb = pat_b[15 - s_rise];
            end
            s_rise++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one frame and checks shape, command data, timing and results
    task automatic run_frame(input bit exp_cfg, input logic [15:0] pa,
                             input logic [15:0] pb, input bit poke);
        int falls = 0, rises = 0, lead = 0, trail = 0, hi = 0, lo = 0;
        int bad_phase = 0, busy_bad = 0, cyc = 0, extra = 0;
        int nb = exp_cfg ? 32 : 16;
        bit poked = 0;
        logic prev_s = 1'b0;
        logic [31:0] mbits = '0;
        logic [31:0] exp_m = exp_cfg ? 32'h8800_0000 : 32'h0;
        pat_a = pa;
        pat_b = pb;
        @(negedge clk) trigger = 1'b1;
        @(negedge clk) trigger = 1'b0;
        while (!cs_n && cyc < 2000) begin
            trigger = 1'b0;
            if (!busy) busy_bad++;
            if (sclk && !prev_s) begin
                rises++;
                if (rises > 1 && lo != HALF) bad_phase++;
                lo = 0; hi = 0;
            end
            if (!sclk && prev_s) begin
                falls++;
                mbits = {mbits[30:0], mosi};
                if (hi != HALF) bad_phase++;
                hi = 0; lo = 0;
            end
            if (sclk) hi++;
            else if (rises == 0) lead++;
            else if (falls == nb) trail++;
            else lo++;
            if (poke && !poked && falls == 3) begin
                trigger = 1'b1;
                poked = 1;
            end
            prev_s = sclk;
            cyc++;
            @(negedge clk);
        end
        trigger = 1'b0;
        check(falls == nb, exp_cfg ? "R2" : "R3", "falling edges", falls, nb);
        check(mbits == exp_m, exp_cfg ? "R2" : "R3", "command bits", mbits, exp_m);
        check(lead == HALF, "R7", "lead cycles", lead, HALF);
        check(trail == HALF, "R7", "trail cycles", trail, HALF);
        check(bad_phase == 0, "R7", "clock phase errors", bad_phase, 0);
        check(busy_bad == 0, "R8", "busy low in frame", busy_bad, 0);
        check(res_valid == !exp_cfg, exp_cfg ? "R2" : "R5", "valid at end",
              res_valid, !exp_cfg);
        if (!exp_cfg) begin
            check(res_a == pa, "R4", "channel A", res_a, pa);
            check(res_b == pb, "R4", "channel B", res_b, pb);
        end
        for (int i = 0; i < 3 * CLK_DIV; i++) begin
            @(negedge clk);
            if (res_valid || !cs_n || busy) extra++;
        end
        check(extra == 0, poke ? "R8" : "R5", "activity after frame", extra, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk in reset", {cs_n, sclk}, 2'b10);
        check(busy == 1'b0 && res_valid == 1'b0, "R1", "busy/valid in reset",
              {busy, res_valid}, 0);
        check(res_a == 0 && res_b == 0, "R1", "results in reset", {res_a, res_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R1", "idle after release", {cs_n, busy}, 2'b10);
    endtask

    task automatic test_config_frame();
        run_frame(1'b1, 16'hFFFF, 16'hFFFF, 1'b0);   // R2
        check(res_a == 0 && res_b == 0, "R2", "results untouched by config",
              {res_a, res_b}, 0);
    endtask

    task automatic test_read_frames();
        run_frame(1'b0, 16'hA5A5, 16'h3C0F, 1'b0);   // R3 R4 R5
        run_frame(1'b0, 16'hFFFF, 16'h0000, 1'b0);
        run_frame(1'b0, 16'h8001, 16'h7FFE, 1'b0);
    endtask

    task automatic test_busy_ignore();
        run_frame(1'b0, 16'h1234, 16'hFEDC, 1'b1);   // R8
    endtask

    task automatic test_idle_ignore();
        logic [15:0] ka = res_a, kb = res_b;
        int bad = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            idle_a = i[0];
            idle_b = i[1];
            if (res_valid || res_a != ka || res_b != kb) bad++;
        end
        check(bad == 0, "R9", "idle data-line activity", bad, 0);
        idle_a = 1'b1;
        idle_b = 1'b1;
        run_frame(1'b0, 16'h0F0F, 16'hC003, 1'b0);   // R9 read still correct
    endtask

    task automatic test_rereset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(res_a == 0 && cs_n == 1'b1, "R1", "second reset state", {res_a, 15'b0, cs_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(1'b1, 16'h0000, 16'h0000, 1'b0);   // R10
        run_frame(1'b0, 16'h5AA5, 16'h6699, 1'b0);   // R10
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_config_frame();
        test_read_frames();
        test_busy_ignore();
        test_idle_ignore();
        test_rereset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule